// File: doc/BRIEF.md
# I2S Master Transmit Serializer

This block turns a stream of 32-bit channel words, read from a show-ahead word FIFO, into a standard I2S serial output. It is master of both serial clocks: it derives the bit clock from a master-clock enable with a programmable divider, drives word-select, and shifts sample data MSB first. Each frame takes one word for the left channel and then one word for the right. When the sample resolution is below the word width, only the low-order resolution bits of each word are sent.

A controller sets the clock ratio and resolution, fills the FIFO and raises the transmit enable. The block then sends one frame of zeros, left channel first. After that it streams queued data. If the FIFO is empty when a slot starts, that slot is filled with zeros and nothing is popped. Dropping the enable returns every output to a quiet low level.

The controller has three states. `TXS_IDLE` holds the outputs low, and its *start* transition, on enable, latches ratio and resolution and enters `TXS_ZERO`. `TXS_ZERO` sends the all-zero priming frame, and its *prime-done* transition, taken at the falling bit-clock edge that closes that frame, enters `TXS_STREAM`, where FIFO words are consumed. The *stop* transition from either active state back to `TXS_IDLE` is taken whenever the enable is sampled low.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset, and from the cycle after `tx_en` is sampled low, `bclk`, `ws`, `sdata` and `fifo_pop` are all 0.
- R2: Each half period of `bclk` lasts `ratio`+2 cycles in which `mclk_en` is high, so the bit clock is the master rate divided by 2·(`ratio`+2). The first half period after enabling is the low one.
- R3: A frame lasts 2·`res` bit-clock periods: `res` bits for the left slot, then `res` bits for the right slot. `ws` is 0 for left and 1 for right, and it changes on the falling `bclk` edge one bit before each slot's MSB.
- R4: Data is sent MSB first. `sdata` and `ws` change only at falling `bclk` edges and are stable while `bclk` is high.
- R5: Only bits `res`-1 down to 0 of a FIFO word are transmitted. Higher bits have no effect.
- R6: After `tx_en` rises, the first frame is all zeros, and no word is popped during it.
- R7: In the streaming state, a word is popped at the falling edge that starts each slot, left word then right word. The pop pulse is one cycle long and `bclk` is low in the cycle after it.
- R8: When `fifo_empty` is 1 at a slot start, the slot carries zeros and `fifo_pop` stays 0.
- R9: `ratio` and `res` are sampled when transmission starts. Changes to them while enabled have no effect until the next start.
- R10: Disabling in the middle of a frame and enabling again restarts with a full zero frame beginning at the left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_en | input | 1 | One-cycle enable marking each master-clock tick |
| tx_en | input | 1 | Transmit enable |
| ratio | input | RATIO_W | Bit-clock divider setting |
| res | input | RES_W | Sample resolution in bits (clamped to 2..SAMPLE_W) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | SAMPLE_W | Head word of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Consume the head word |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word-select, 0 = left, 1 = right |
| sdata | output | 1 | Serial data |

## Verification
The serializer is driven with three resolutions (8, 16 and 32 bits), with data words whose upper bits carry deliberate garbage, and with word counts that run the FIFO dry partway through a frame. This separates correct truncation and MSB ordering from off-by-one slot alignment, and it shows whether an empty slot is filled with zeros. The divider is tried with a free-running master enable and with one that pulses every other cycle, which distinguishes counting enables from counting clocks. Changing ratio and resolution while enabled, and aborting a frame and restarting, confirm that settings are latched and that the zero priming frame is sent again.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        TXS_IDLE   = 2'd0,
        TXS_ZERO   = 2'd1,
        TXS_STREAM = 2'd2
    } txs_e;

endpackage

// File: rtl/i2s_tx_bitclk.sv
// Bit clock generator: toggles after ratio+2 master-clock enables and
// flags the cycle whose edge produces a falling bit clock.
module i2s_tx_bitclk #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               mclk_en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               bclk,
    output logic               fall_tick
);
    localparam int CNT_W = RATIO_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             at_last;

    assign last      = CNT_W'(ratio) + CNT_W'(1);
    assign at_last   = mclk_en && (cnt == last);
    assign fall_tick = run && at_last && bclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (mclk_en) begin
            if (cnt == last) begin
                cnt  <= '0;
                bclk <= ~bclk;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/i2s_tx_shifter.sv
// MSB-first output shift register with parallel load.
module i2s_tx_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_val,
    output logic         msb
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (clr) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_val;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    assign msb = sreg[W-1];
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_tx_pkg::*;
#(
    parameter  int SAMPLE_W = 32,
    parameter  int RATIO_W  = 8,
    localparam int RES_W    = $clog2(SAMPLE_W) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mclk_en,
    input  logic                tx_en,
    input  logic [RATIO_W-1:0]  ratio,
    input  logic [RES_W-1:0]    res,
    input  logic                fifo_empty,
    input  logic [SAMPLE_W-1:0] fifo_data,
    output logic                fifo_pop,
    output logic                bclk,
    output logic                ws,
    output logic                sdata
);
    localparam int SLOT_W  = $clog2(2 * SAMPLE_W);
    localparam int MIN_RES = 2;

    txs_e                state, state_nx;
    logic [RES_W-1:0]    res_q, res_clamped, pad;
    logic [RATIO_W-1:0]  ratio_q;
    logic [SLOT_W-1:0]   k, kn;
    logic [SLOT_W:0]     last_slot;
    logic                div_bclk, fall_tick, run;
    logic                slot_start, take_word, ws_next, msb;
    logic [SAMPLE_W-1:0] aligned, load_val;

    // resolution clamp applied when settings are latched
    always_comb begin
        if (res < RES_W'(MIN_RES))
            res_clamped = RES_W'(MIN_RES);
        else if (res > RES_W'(SAMPLE_W))
            res_clamped = RES_W'(SAMPLE_W);
        else
            res_clamped = res;
    end

    assign run = (state != TXS_IDLE);

    i2s_tx_bitclk #(.RATIO_W(RATIO_W)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mclk_en   (mclk_en),
        .ratio     (ratio_q),
        .bclk      (div_bclk),
        .fall_tick (fall_tick)
    );

    // slot position bookkeeping
    assign last_slot  = (SLOT_W+1)'({res_q, 1'b0}) - (SLOT_W+1)'(1);
    assign kn         = ({1'b0, k} == last_slot) ? '0 : k + SLOT_W'(1);
    assign slot_start = fall_tick &&
                        ((kn == '0) || ((SLOT_W+1)'(kn) == (SLOT_W+1)'(res_q)));
    assign ws_next    = ((SLOT_W+1)'(kn) >= (SLOT_W+1)'(res_q));
    assign take_word  = tx_en && slot_start &&
                        ((state == TXS_STREAM) || ((state == TXS_ZERO) && (kn == '0)));

    assign pad      = RES_W'(SAMPLE_W) - res_q;
    assign aligned  = fifo_data << pad;
    assign load_val = fifo_pop ? aligned : '0;

    i2s_tx_shifter #(.W(SAMPLE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == TXS_IDLE),
        .load     (slot_start),
        .shift    (fall_tick && !slot_start),
        .load_val (load_val),
        .msb      (msb)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXS_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            TXS_IDLE:   if (tx_en) state_nx = TXS_ZERO;
            TXS_ZERO: begin
                if (!tx_en)                       state_nx = TXS_IDLE;
                else if (fall_tick && kn == '0)   state_nx = TXS_STREAM;
            end
            TXS_STREAM: if (!tx_en) state_nx = TXS_IDLE;
            default:    state_nx = TXS_IDLE;
        endcase
    end

    // settings latch and slot counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k       <= '0;
            res_q   <= RES_W'(SAMPLE_W);
            ratio_q <= '0;
        end else if (state == TXS_IDLE) begin
            k <= '0;
            if (tx_en) begin
                res_q   <= res_clamped;
                ratio_q <= ratio;
            end
        end else if (fall_tick) begin
            k <= kn;
        end
    end

    // outputs
    always_comb begin
        bclk     = 1'b0;
        ws       = 1'b0;
        sdata    = 1'b0;
        fifo_pop = 1'b0;
        unique case (state)
            TXS_IDLE: ;
            TXS_ZERO, TXS_STREAM: begin
                bclk     = div_bclk;
                ws       = ws_next;
                sdata    = msb;
                fifo_pop = take_word && !fifo_empty;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic fifo_empty,
    input logic fifo_pop,
    input logic bclk,
    input logic ws,
    input logic sdata
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!bclk && !ws && !sdata && !fifo_pop));

    // R4
    stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk && $past(bclk)) |-> ($stable(sdata) && $stable(ws)));

    // R8
    empty_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_pop);

    // R7
    pop_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (!bclk && !fifo_pop));
endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .bclk       (bclk),
    .ws         (ws),
    .sdata      (sdata)
);

// File: tb/i2s_tx_serializer_test.sv
module i2s_tx_serializer_test;
    localparam int RW   = 8;
    localparam int RESW = 6;

    typedef struct {
        logic  ws;
        logic  sd;
        string tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mclk_en = 1'b1;
    logic            tx_en = 1'b0;
    logic [RW-1:0]   ratio = '0;
    logic [RESW-1:0] res = 6'd16;
    logic            fifo_empty = 1'b1;
    logic [31:0]     fifo_data = '0;
    logic            fifo_pop, bclk, ws, sdata;

    int    n_chk = 0;
    int    n_err = 0;
    int    pops = 0;
    bit    slow_mclk = 1'b0;
    logic [31:0] fq[$];
    logic [31:0] wq[$];
    item_t exq[$];

    always #4 clk = ~clk;

    i2s_tx_serializer uut (
        .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .tx_en(tx_en),
        .ratio(ratio), .res(res), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .bclk(bclk), .ws(ws), .sdata(sdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    function automatic void refresh();
        fifo_empty = (fq.size() == 0);
        fifo_data  = (fq.size() != 0) ? fq[0] : 32'h0;
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // master clock enable source
    initial forever begin
        @(negedge clk);
        mclk_en = slow_mclk ? ~mclk_en : 1'b1;
    end

    // FIFO model: sees pop mid-cycle, retires the word just after the edge
    initial forever begin
        logic p;
        @(negedge clk);
        p = fifo_pop;
        @(posedge clk);
        #1;
        if (p && fq.size() != 0) begin
            void'(fq.pop_front());
            pops++;
            refresh();
        end
    end

    // monitor: compares each bit-clock high phase against the scoreboard
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (bclk && !prev && exq.size() != 0) begin
                item_t it;
                it = exq.pop_front();
                chk(ws === it.ws, "R3", "ws", ws, it.ws);
                chk(sdata === it.sd, it.tag, "sdata", sdata, it.sd);
            end
            prev = bclk;
        end
    end

    // driver side of the scoreboard: one frame of expected bit items
    task automatic push_frame(input int r, input logic [31:0] lw, input logic [31:0] rw,
                              input string tl, input string tr);
        for (int k = 0; k < 2 * r; k++) begin
            item_t it;
            logic [31:0] w;
            w     = (k < r) ? lw : rw;
            it.ws = (((k + 1) % (2 * r)) >= r);
            it.sd = w[r - 1 - (k % r)];
            it.tag = (k < r) ? tl : tr;
            exq.push_back(it);
        end
    endtask

    task automatic measure(output int cyc);
        logic p;
        int c;
        p = bclk;
        forever begin @(negedge clk); if (bclk && !p) break; p = bclk; end
        c = 0;
        p = bclk;
        forever begin @(negedge clk); c++; if (bclk && !p) break; p = bclk; end
        cyc = c;
    endtask

    task automatic run_case(input int r, input int rat, input int nframes,
                            input string tag, input string ztag, input bit alter);
        int exp_pops;
        int per;
        res   = RESW'(r);
        ratio = RW'(rat);
        foreach (wq[i]) fq.push_back(wq[i]);
        refresh();
        exp_pops = (wq.size() < 2 * nframes) ? wq.size() : 2 * nframes;
        push_frame(r, 32'h0, 32'h0, ztag, ztag);
        for (int f = 0; f < nframes; f++) begin
            bit hl, hr;
            hl = (2 * f) < wq.size();
            hr = (2 * f + 1) < wq.size();
            push_frame(r, hl ? wq[2*f] : 32'h0, hr ? wq[2*f+1] : 32'h0,
                       hl ? tag : "R8", hr ? tag : "R8");
        end
        pops = 0;
        step();
        tx_en = 1'b1;
        if (alter) begin
            step();
            res   = 6'd8;
            ratio = 8'd6;
            measure(per);
            chk(per == 2 * (rat + 2), "R9", "bclk period after change", per, 2 * (rat + 2));
        end
        while (exq.size() != 0) @(negedge clk);
        chk(pops == exp_pops, "R7", "pop count", pops, exp_pops);
        step();
        tx_en = 1'b0;
        @(negedge clk);
        chk({bclk, ws, sdata, fifo_pop} == 4'b0, "R1", "outputs after disable",
            {bclk, ws, sdata, fifo_pop}, 0);
        repeat (4) step();
        fq.delete();
        refresh();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        int per;
        refresh();
        repeat (3) step();
        chk({bclk, ws, sdata, fifo_pop} == 4'b0, "R1", "outputs in reset",
            {bclk, ws, sdata, fifo_pop}, 0);
        rst_n = 1'b1;
        repeat (3) step();
        chk({bclk, ws, sdata, fifo_pop} == 4'b0, "R1", "idle after reset",
            {bclk, ws, sdata, fifo_pop}, 0);

        // R4: 16-bit, FIFO drains mid-frame (R8 slots), one extra empty frame
        wq = {32'h0000_1234, 32'h0000_BEEF, 32'h0000_8001, 32'h0000_7FFE, 32'h0000_00C3};
        run_case(16, 2, 4, "R4", "R6", 1'b0);

        // R4: full 32-bit words
        wq = {32'h8000_0001, 32'hDEAD_BEEF, 32'h0F0F_0F0F, 32'hF0F0_F0F0};
        run_case(32, 0, 2, "R4", "R6", 1'b0);

        // R5: 8-bit resolution, upper bits are garbage
        wq = {32'hABCD_E5A3, 32'h1234_567F};
        run_case(8, 0, 1, "R5", "R6", 1'b0);

        // R2: divider counts master enables, not clocks
        res   = 6'd16;
        ratio = 8'd3;
        step();
        tx_en = 1'b1;
        measure(per);
        chk(per == 10, "R2", "bclk period, enable every cycle", per, 10);
        slow_mclk = 1'b1;
        measure(per);
        measure(per);
        chk(per == 20, "R2", "bclk period, enable every other cycle", per, 20);
        step();
        tx_en = 1'b0;
        slow_mclk = 1'b0;
        repeat (4) step();

        // R9: settings changed while running are ignored
        wq = {32'hFFFF_0001, 32'h0001_8000};
        run_case(16, 1, 1, "R9", "R6", 1'b1);

        // R10: abort inside a stream, restart sends a zero frame again
        res   = 6'd16;
        ratio = 8'd0;
        fq    = {32'h0000_5555, 32'h0000_AAAA, 32'h0000_3333, 32'h0000_CCCC};
        refresh();
        step();
        tx_en = 1'b1;
        repeat (150) step();
        tx_en = 1'b0;
        @(negedge clk);
        chk({bclk, ws, sdata} == 3'b0, "R1", "outputs after mid-frame abort",
            {bclk, ws, sdata}, 0);
        repeat (3) step();
        fq.delete();
        refresh();
        wq = {32'h0000_F00D, 32'h0000_0BAD};
        run_case(16, 0, 1, "R10", "R10", 1'b0);

        report();
        $finish;
    end
endmodule